// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic down-counting timer that raises a tick interrupt request. Software loads a reload value, selects whether the count advances on every core clock cycle or on a divided step that comes once every `DIV` core cycles, and sets the run bit. The counter steps down to zero and raises a sticky zero flag, plus an interrupt pulse when interrupts are enabled. On the following count step it loads the reload value again, so a reload value of N-1 gives one request every N count steps.

Three word registers sit on a simple single-cycle register bus. A request with the write strobe set writes in the cycle it is presented. A read request returns data on `rdata_o` in the following cycle, and that value is held until the next read. A new reload value does not shorten or lengthen the period in progress. Writing the current-value register forces the counter to zero, so the next count step starts a fresh period from the reload value.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value registers read as zero and `irq_o` is low.
- R2: The registers are at byte offsets 0x10 (control/status), 0x14 (reload) and 0x18 (current value). Control bit 0 is the run enable, bit 1 is the interrupt enable, bit 2 selects the clock source (1 = core clock, 0 = divided step) and bit 16 is the read-only zero flag. All other control bits, and every other address, read as zero. Read data appears on `rdata_o` in the cycle after the request.
- R3: With the core clock selected, the counter moves once per cycle. A step at zero loads the reload value and any other step decrements, so the period is reload+1 steps.
- R4: A step that moves the counter from 1 to 0 sets the zero flag. When the interrupt enable is set, the same step also drives `irq_o` high for exactly that one cycle.
- R5: With the divided source selected, count steps (counting and reloading) occur only once every `DIV` core cycles, measured from the cycle the run bit is set. The period is (reload+1)*`DIV` cycles.
- R6: The zero flag stays set until the control/status register is read. That read returns the flag as it was and then clears it. A flag being set in the same cycle as such a read takes priority over the clear.
- R7: A reload write does not change the period in progress. The new value takes effect at the next reload.
- R8: Any write to the current-value register sets the counter and the zero flag to zero.
- R9: With a reload value of zero, the counter stays at zero and neither the flag nor `irq_o` is raised.
- R10: While the run bit is clear, the counter holds its value and the divided-step prescaler is held at its start.
- R11: The reload and current-value registers are `CNT_W` bits wide. Writes drop the upper data bits, and reads return zero above bit `CNT_W`-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write strobe (1 = write, 0 = read) |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle after a read request |
| irq_o | output | 1 | Tick interrupt request, one-cycle pulse |

## Verification
The bench builds the block with `CNT_W` = 12 and `DIV` = 4. With these values, divided-step periods are only a dozen cycles long, so several full periods fit in a short run. Writing all ones to the reload register then shows the truncation to twelve bits at the read-back. Each clock, a behavioural model of the counter, prescaler and flag predicts `irq_o` and `rdata_o`. This model follows the counter through several cases: changes of clock source while running, pauses of the run bit, reload writes in the middle of a period, forced clears, and the zero-reload rest state.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned OFF_CTRL    = 32'h10;
  localparam int unsigned OFF_RELOAD  = 32'h14;
  localparam int unsigned OFF_CURRENT = 32'h18;

  localparam int CB_RUN    = 0;
  localparam int CB_IRQ_EN = 1;
  localparam int CB_SRC    = 2;
  localparam int CB_FLAG   = 16;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic div_step_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           pre_q <= '0;
        else if (!en_i)        pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
      end

      assign div_step_o = en_i && (pre_q == LAST);

      AST_DIV_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_step_o |=> !div_step_o); // R5
      AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !div_step_o); // R10
    end else begin : g_nodiv
      assign div_step_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (step_i) begin
      if (cnt_q == '0)     cnt_q <= reload_i;
      else                 cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i && !clr_i && (cnt_q == ONE);

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i && (cnt_q == '0) |=> cnt_q == $past(reload_i)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !clr_i |=> $stable(cnt_q)); // R10
  AST_FORCE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R8
  AST_WRAP_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0); // R4
  AST_ZERO_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && (reload_i == '0) |=> cnt_q == '0); // R9
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_wr_o
);
  logic sel_ctrl, sel_reload, sel_cur, wr, rd;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic flag_q;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic unused_wdata;

  assign sel_ctrl   = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_reload = addr_i == ADDR_W'(OFF_RELOAD);
  assign sel_cur    = addr_i == ADDR_W'(OFF_CURRENT);
  assign wr         = req_i && we_i;
  assign rd         = req_i && !we_i;
  assign cur_wr_o   = wr && sel_cur;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr) begin
      if (sel_ctrl) begin
        ctrl_q.run      <= wdata_i[CB_RUN];
        ctrl_q.irq_en   <= wdata_i[CB_IRQ_EN];
        ctrl_q.src_core <= wdata_i[CB_SRC];
      end
      if (sel_reload) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  // set beats read-clear; a forced clear cannot coincide with a wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (cur_wr_o)        flag_q <= 1'b0;
    else if (wrap_i)          flag_q <= 1'b1;
    else if (rd && sel_ctrl)  flag_q <= 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (sel_ctrl) begin
      rd_val[CB_RUN]    = ctrl_q.run;
      rd_val[CB_IRQ_EN] = ctrl_q.irq_en;
      rd_val[CB_SRC]    = ctrl_q.src_core;
      rd_val[CB_FLAG]   = flag_q;
    end else if (sel_reload) begin
      rd_val = DATA_W'(reload_q);
    end else if (sel_cur) begin
      rd_val = DATA_W'(cnt_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o  = rdata_q;
  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q); // R6
  AST_FLAG_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel_ctrl && !wrap_i |=> !flag_q); // R6
  AST_RELOAD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel_reload) |=> $stable(reload_q)); // R7
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DIV    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic cur_wr, wrap, div_step, step, irq_q;

  tick_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .wrap_i(wrap), .ctrl_o(ctrl), .reload_o(reload), .cur_wr_o(cur_wr)
  );

  tick_prescale #(.DIV(DIV)) u_pre (
    .clk_i, .rst_ni, .en_i(ctrl.run), .div_step_o(div_step)
  );

  assign step = ctrl.run && (ctrl.src_core || div_step);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .clr_i(cur_wr), .reload_i(reload),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap && ctrl.irq_en;
  end
  assign irq_o = irq_q;

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R4
  AST_IRQ_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt == '0 || $past(cur_wr) == 1'b0); // R4
  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |=> !irq_o); // R10
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam int CNT_W = 12;
  localparam int DIV   = 4;
  localparam int MASK  = (1 << CNT_W) - 1;
  localparam int A_CTRL = 'h10, A_REL = 'h14, A_CUR = 'h18;

  logic clk_i = 0, rst_ni = 0, req_i = 0, we_i = 0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic irq_o;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";
  int irq_times[$];

  // reference model state
  int m_run, m_ie, m_src, m_rel, m_cnt, m_flag, m_pre, m_irq;
  logic [31:0] m_rdata;

  always #5 clk_i = ~clk_i;

  tick_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(CNT_W), .DIV(DIV)) u_tick_timer (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_ie = 0; m_src = 0; m_rel = 0; m_cnt = 0;
      m_flag = 0; m_pre = 0; m_irq = 0; m_rdata = 0;
    end else begin
      int step, wrap, a;
      bit wr, rd;
      cyc++;
      a = int'(addr_i);
      wr = req_i && we_i;
      rd = req_i && !we_i;
      step = m_run && (m_src || m_pre == DIV - 1);
      wrap = 0;
      if (rd) begin
        if (a == A_CTRL) m_rdata = 32'(m_run | (m_ie << 1) | (m_src << 2) | (m_flag << 16));
        else if (a == A_REL) m_rdata = 32'(m_rel);
        else if (a == A_CUR) m_rdata = 32'(m_cnt);
        else m_rdata = 0;
      end
      if (!m_run) m_pre = 0;
      else m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      if (wr && a == A_CUR) m_cnt = 0;
      else if (step) begin
        if (m_cnt == 0) m_cnt = m_rel;
        else begin
          if (m_cnt == 1) wrap = 1;
          m_cnt--;
        end
      end
      if (wr && a == A_CUR) m_flag = 0;
      else if (wrap) m_flag = 1;
      else if (rd && a == A_CTRL) m_flag = 0;
      m_irq = wrap && m_ie;
      if (wr && a == A_CTRL) begin
        m_run = int'(wdata_i[0]); m_ie = int'(wdata_i[1]); m_src = int'(wdata_i[2]);
      end
      if (wr && a == A_REL) m_rel = int'(wdata_i) & MASK;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      vectors++;
      if (irq_o !== m_irq[0] || rdata_o !== m_rdata) begin
        fails++;
        $display("FAIL %s cycle %0d: irq=%0b rdata=%h, expected irq=%0b rdata=%h",
                 cur_req, cyc, irq_o, rdata_o, m_irq[0], m_rdata);
      end
      if (irq_o) irq_times.push_back(cyc);
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 8'(a); wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = 8'(a);
    @(negedge clk_i);
    req_i = 0;
    #1 d = rdata_o;
  endtask

  task automatic wait_irqs(input int n);
    int guard = 0;
    while (irq_times.size() < n && guard < 5000) begin
      @(negedge clk_i); #1;
      guard++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    int limit = 100000;
    while (cyc < limit) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, limit);
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    #23 rst_ni = 1;

    cur_req = "R1";
    check("R1 irq after reset", 32'(irq_o), 0);
    bus_rd(A_CTRL, v); check("R1 ctrl reset", v, 0);
    bus_rd(A_REL, v);  check("R1 reload reset", v, 0);
    bus_rd(A_CUR, v);  check("R1 current reset", v, 0);

    cur_req = "R3";
    bus_wr(A_REL, 5);
    bus_wr(A_CTRL, 32'h7);
    irq_times.delete();
    wait_irqs(2);
    check("R3 core period", 32'(irq_times[1] - irq_times[0]), 6);
    cur_req = "R7";
    bus_wr(A_REL, 9);
    wait_irqs(4);
    check("R7 running period kept", 32'(irq_times[2] - irq_times[1]), 6);
    check("R7 new period at reload", 32'(irq_times[3] - irq_times[2]), 10);

    cur_req = "R6";
    bus_rd(A_CTRL, v); check("R6 flag read", v, 32'h10007);
    bus_rd(A_CTRL, v); check("R6 flag cleared by read", v, 32'h7);

    cur_req = "R4";
    bus_wr(A_CTRL, 32'h5);
    irq_times.delete();
    idle(40);
    check("R4 no irq when disabled", 32'(irq_times.size()), 0);
    bus_rd(A_CTRL, v); check("R4 flag still set", v, 32'h10005);

    cur_req = "R5";
    bus_wr(A_REL, 2);
    bus_wr(A_CTRL, 32'h3);
    irq_times.delete();
    wait_irqs(3);
    check("R5 divided period a", 32'(irq_times[1] - irq_times[0]), 3 * DIV);
    check("R5 divided period b", 32'(irq_times[2] - irq_times[1]), 3 * DIV);

    cur_req = "R10";
    bus_wr(A_CTRL, 32'h2);
    bus_rd(A_CUR, v);
    irq_times.delete();
    idle(20);
    bus_rd(A_CUR, v2);
    check("R10 counter held", v2, v);
    check("R10 no irq while stopped", 32'(irq_times.size()), 0);
    bus_wr(A_CTRL, 32'h3);

    cur_req = "R8";
    irq_times.delete();
    wait_irqs(1);
    bus_wr(A_CUR, 32'h123);
    bus_rd(A_CUR, v);  check("R8 current cleared", v, 0);
    bus_rd(A_CTRL, v); check("R8 flag cleared", v, 32'h3);

    cur_req = "R9";
    bus_wr(A_REL, 0);
    bus_wr(A_CUR, 0);
    bus_rd(A_CTRL, v);
    irq_times.delete();
    idle(50);
    check("R9 no irq at zero reload", 32'(irq_times.size()), 0);
    bus_rd(A_CTRL, v); check("R9 no flag at zero reload", v, 32'h3);
    bus_rd(A_CUR, v);  check("R9 counter rests at zero", v, 0);

    cur_req = "R11";
    bus_wr(A_REL, 32'hFFFF_FFFF);
    bus_rd(A_REL, v); check("R11 reload truncated", v, 32'(MASK));
    cur_req = "R2";
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, v); check("R2 control layout", v, 32'h7);
    idle(3);
    bus_rd(A_CUR, v); check("R11 current upper bits", v >> CNT_W, 0);
    bus_rd('h1C, v);  check("R2 unmapped address", v, 0);

    idle(2);
    finish_run();
  end
endmodule